// File: doc/BRIEF.md
# Trimmed Seconds Counter with Match Events

This block keeps time from a slow reference strobe. Each `osc_tick` strobe marks one step of a 32.768 kHz source. A predivider counts these steps. When it wraps, it produces a one-second tick that advances a seconds counter. The counter is 32 bits wide by default.

Most seconds last exactly `2**SUB_W` steps. Every `TRIM_EVERY`-th second instead runs from zero up to `trim_value`. This lets firmware correct the rate for a source that is slightly fast or slow without disturbing ordinary seconds.

Two comparators watch the counters:
- One compares the seconds count together with the sub-second count.
- The other compares the seconds count alone.

Each hit latches a raw status bit that stays set until it is cleared by writing 1 to it. A mask selects which raw bits reach the masked status and the interrupt/wake line.

The block lives in the always-on clock domain. The `osc_tick` input is a single-cycle enable in that domain. All configuration inputs are plain levels. `load_strobe` and `status_clr` are single-cycle write pulses. The block has no streaming data path, so it uses no valid/ready handshake.

Top module: `rtc_trim_counter`

## Requirements
- R1: After reset, `sec_count`, `sub_count`, `raw_status`, `masked_status` and `irq` are all zero, and the trim epoch starts at its first second.
- R2: `sub_count` advances by one on every cycle that has both `osc_tick` and `run_en` high. It holds its value in every other cycle unless a load occurs.
- R3: An untrimmed second lasts `2**SUB_W` steps. When `sub_count` passes `2**SUB_W-1`, it returns to 0 and `sec_count` increments by one, wrapping modulo `2**SEC_W`.
- R4: Seconds are numbered from 0 since the last reset or load, modulo `TRIM_EVERY`. The second with index `TRIM_EVERY-1` lasts `trim_value+1` steps, and all other seconds use the nominal length. A `trim_value` above `2**SUB_W-1` lengthens that second, and a value below it shortens it.
- R5: A `load_strobe` cycle writes `load_value` into `sec_count` and clears both `sub_count` and the trim epoch. This takes precedence over a step in the same cycle and works even while `run_en` is low.
- R6: Raw status bit 0 sets in the cycle in which the counters take on `sec_count == match0_sec` and `sub_count == match0_sub` (zero-extended), whether by a step or by a load.
- R7: Raw status bit 1 sets in the cycle in which `sec_count` takes on the value `match1_sec`, either by a one-second roll or by a load. Steps within a second do not set it again.
- R8: A 1 in bit i of `status_clr` clears raw bit i on the next edge. When a hit on bit i coincides with its clear, the bit stays set.
- R9: `masked_status` equals `raw_status & irq_mask` at all times, and `irq` is the OR of `masked_status`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One 1/32768 s step of the reference source |
| run_en | input | 1 | Counting enable |
| load_strobe | input | 1 | Write pulse for the seconds counter |
| load_value | input | SEC_W | Value written by `load_strobe` |
| trim_value | input | TRIM_W | Terminal count of the trimmed second (nominal `2**SUB_W-1`) |
| match0_sec | input | SEC_W | Seconds compare value for event 0 |
| match0_sub | input | SUB_W | Sub-second compare value for event 0 |
| match1_sec | input | SEC_W | Seconds compare value for event 1 |
| irq_mask | input | 2 | Per-event interrupt mask |
| status_clr | input | 2 | Write-1-to-clear pulse for raw status |
| sec_count | output | SEC_W | Seconds counter |
| sub_count | output | TRIM_W | Predivider count (sub-second steps into the current second) |
| raw_status | output | 2 | Latched events: bit 0 match 0, bit 1 match 1 |
| masked_status | output | 2 | Raw status gated by mask |
| irq | output | 1 | Any masked event pending |

## Verification
Two pairs of functions can land on the same edge.

The first pair is a status clear and a fresh hit on the same bit. To provoke it, the bench sets `match1_sec` equal to a value it is about to load and pulses `status_clr[1]` in the load cycle. The bit must survive.

The second pair is a load and a step. The bench keeps `osc_tick` high across every load, and expects the loaded value with a zero sub-count rather than an increment.

A behavioural reference model, built from integers, follows every edge. Its result is compared with each output on every cycle. Directed second-length measurements check the trimmed epoch with the trim above, at and below nominal.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_EV   = 2;
  localparam int EV_MATCH0 = 0;
  localparam int EV_MATCH1 = 1;
  typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/rtc_prediv.sv
module rtc_prediv #(
  parameter int SUB_W      = 15,
  parameter int TRIM_W     = SUB_W + 1,
  parameter int TRIM_EVERY = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              restart,
  input  logic [TRIM_W-1:0] trim,
  output logic [TRIM_W-1:0] cnt_q,
  output logic [TRIM_W-1:0] cnt_next,
  output logic              sec_tick
);
  localparam int EP_W = (TRIM_EVERY > 1) ? $clog2(TRIM_EVERY) : 1;
  localparam logic [TRIM_W-1:0] NOMINAL = TRIM_W'((1 << SUB_W) - 1);
  localparam logic [EP_W-1:0]   EP_LAST = EP_W'(TRIM_EVERY - 1);

  logic [EP_W-1:0]   epoch_q, epoch_next;
  logic [TRIM_W-1:0] limit;
  logic              at_end;

  // The trimmed second is the last one of each epoch.
  assign limit  = (epoch_q == EP_LAST) ? trim : NOMINAL;
  // >= so that a trim lowered below the running count still ends the second.
  assign at_end = (cnt_q >= limit);

  assign sec_tick = step && at_end && !restart;

  always_comb begin
    cnt_next   = cnt_q;
    epoch_next = epoch_q;
    if (restart) begin
      cnt_next   = '0;
      epoch_next = '0;
    end else if (step) begin
      if (at_end) begin
        cnt_next   = '0;
        epoch_next = (epoch_q == EP_LAST) ? '0 : epoch_q + 1'b1;
      end else begin
        cnt_next = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      epoch_q <= '0;
    end else begin
      cnt_q   <= cnt_next;
      epoch_q <= epoch_next;
    end
  end

  AST_SUB_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !restart) |=> $stable(cnt_q)); // R2
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0 && epoch_q == '0)); // R5
  AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart && !at_end) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEC_W-1:0] load_value,
  input  logic             sec_tick,
  output logic [SEC_W-1:0] sec_q,
  output logic [SEC_W-1:0] sec_next
);
  always_comb begin
    if (load)          sec_next = load_value;
    else if (sec_tick) sec_next = sec_q + 1'b1;
    else               sec_next = sec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sec_q <= '0;
    else        sec_q <= sec_next;
  end

  AST_SEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sec_q == $past(load_value))); // R5
  AST_SEC_INCR: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !load) |=> (sec_q == $past(sec_q) + 1'b1)); // R3
  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !load) |=> $stable(sec_q)); // R3
endmodule

// File: rtl/rtc_events.sv
module rtc_events
  import rtc_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int SUB_W  = 15,
  parameter int TRIM_W = SUB_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_adv,
  input  logic              sec_adv,
  input  logic [SEC_W-1:0]  sec_next,
  input  logic [TRIM_W-1:0] cnt_next,
  input  logic [SEC_W-1:0]  m0_sec,
  input  logic [SUB_W-1:0]  m0_sub,
  input  logic [SEC_W-1:0]  m1_sec,
  input  ev_vec_t           clr,
  input  ev_vec_t           mask,
  output ev_vec_t           raw,
  output ev_vec_t           masked
);
  ev_vec_t hit;

  // Events fire only on the edge where the counters move into the match state.
  assign hit[EV_MATCH0] = any_adv && (sec_next == m0_sec) &&
                          (cnt_next == TRIM_W'(m0_sub));
  assign hit[EV_MATCH1] = sec_adv && (sec_next == m1_sec);

  for (genvar i = 0; i < NUM_EV; i++) begin : g_stat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      raw[i] <= 1'b0;
      else if (hit[i]) raw[i] <= 1'b1;
      else if (clr[i]) raw[i] <= 1'b0;
    end
  end

  assign masked = raw & mask;

  AST_HIT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((raw & $past(hit)) == $past(hit))); // R6
  AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~hit)) |=> ((raw & $past(clr & ~hit)) == '0)); // R8
  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0) |=> ((raw & $past(raw)) == $past(raw))); // R8
endmodule

// File: rtl/rtc_trim_counter.sv
module rtc_trim_counter
  import rtc_pkg::*;
#(
  parameter int SEC_W      = 32,
  parameter int SUB_W      = 15,
  parameter int TRIM_W     = SUB_W + 1,
  parameter int TRIM_EVERY = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              run_en,
  input  logic              load_strobe,
  input  logic [SEC_W-1:0]  load_value,
  input  logic [TRIM_W-1:0] trim_value,
  input  logic [SEC_W-1:0]  match0_sec,
  input  logic [SUB_W-1:0]  match0_sub,
  input  logic [SEC_W-1:0]  match1_sec,
  input  logic [1:0]        irq_mask,
  input  logic [1:0]        status_clr,
  output logic [SEC_W-1:0]  sec_count,
  output logic [TRIM_W-1:0] sub_count,
  output logic [1:0]        raw_status,
  output logic [1:0]        masked_status,
  output logic              irq
);
  logic              step;
  logic              sec_tick;
  logic [TRIM_W-1:0] cnt_next;
  logic [SEC_W-1:0]  sec_next;
  ev_vec_t           raw_w, masked_w;

  assign step = osc_tick && run_en;

  rtc_prediv #(.SUB_W(SUB_W), .TRIM_W(TRIM_W), .TRIM_EVERY(TRIM_EVERY)) u_prediv (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .restart  (load_strobe),
    .trim     (trim_value),
    .cnt_q    (sub_count),
    .cnt_next (cnt_next),
    .sec_tick (sec_tick)
  );

  rtc_seconds #(.SEC_W(SEC_W)) u_seconds (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_strobe),
    .load_value (load_value),
    .sec_tick   (sec_tick),
    .sec_q      (sec_count),
    .sec_next   (sec_next)
  );

  rtc_events #(.SEC_W(SEC_W), .SUB_W(SUB_W), .TRIM_W(TRIM_W)) u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_adv  (step || load_strobe),
    .sec_adv  (sec_tick || load_strobe),
    .sec_next (sec_next),
    .cnt_next (cnt_next),
    .m0_sec   (match0_sec),
    .m0_sub   (match0_sub),
    .m1_sec   (match1_sec),
    .clr      (status_clr),
    .mask     (irq_mask),
    .raw      (raw_w),
    .masked   (masked_w)
  );

  assign raw_status    = raw_w;
  assign masked_status = masked_w;
  assign irq           = |masked_w;

  AST_SEC_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_strobe && (sec_count != $past(sec_count))) |-> (sub_count == '0)); // R3
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((raw_status & irq_mask) != 2'b00)); // R9
endmodule

// File: tb/tb_rtc_trim_counter.sv
module tb_rtc_trim_counter;
  localparam int SEC_W = 32;
  localparam int SUB_W = 3;
  localparam int TRIM_W = SUB_W + 1;
  localparam int TE = 4;
  localparam int NOM = (1 << SUB_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0, run_en = 1'b0, load_strobe = 1'b0;
  logic [SEC_W-1:0] load_value = '0, match0_sec = '1, match1_sec = '1;
  logic [TRIM_W-1:0] trim_value = TRIM_W'(NOM);
  logic [SUB_W-1:0] match0_sub = '0;
  logic [1:0] irq_mask = 2'b00, status_clr = 2'b00;
  logic [SEC_W-1:0] sec_count;
  logic [TRIM_W-1:0] sub_count;
  logic [1:0] raw_status, masked_status;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_trim_counter #(.SEC_W(SEC_W), .SUB_W(SUB_W), .TRIM_W(TRIM_W), .TRIM_EVERY(TE)) dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .run_en(run_en),
    .load_strobe(load_strobe), .load_value(load_value), .trim_value(trim_value),
    .match0_sec(match0_sec), .match0_sub(match0_sub), .match1_sec(match1_sec),
    .irq_mask(irq_mask), .status_clr(status_clr), .sec_count(sec_count),
    .sub_count(sub_count), .raw_status(raw_status), .masked_status(masked_status),
    .irq(irq)
  );

  // Behavioural reference model
  int m_cnt = 0;
  int m_ep = 0;
  logic [SEC_W-1:0] m_sec = '0;
  logic [1:0] m_raw = 2'b00;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ep = 0; m_sec = '0; m_raw = 2'b00;
    end else begin
      bit st, rolled, h0, h1;
      int lim;
      st = osc_tick && run_en;
      lim = (m_ep == TE - 1) ? int'(trim_value) : NOM;
      rolled = 0;
      if (load_strobe) begin
        m_cnt = 0; m_ep = 0; m_sec = load_value;
      end else if (st) begin
        if (m_cnt >= lim) begin
          m_cnt = 0; m_ep = (m_ep + 1) % TE; m_sec = m_sec + 1; rolled = 1;
        end else m_cnt = m_cnt + 1;
      end
      h0 = (load_strobe || st) && (m_sec == match0_sec) && (m_cnt == int'(match0_sub));
      h1 = (load_strobe || rolled) && (m_sec == match1_sec);
      m_raw = (m_raw & ~status_clr) | {h1, h0};
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison, 5 ns after the active edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      chk(sub_count == TRIM_W'(m_cnt), "R2", "sub_count", sub_count, m_cnt);
      chk(sec_count == m_sec, "R3", "sec_count", sec_count, m_sec);
      chk(raw_status == m_raw, "R6", "raw_status", raw_status, m_raw);
      chk(masked_status == (m_raw & irq_mask), "R9", "masked_status", masked_status, m_raw & irq_mask);
      chk(irq == |(m_raw & irq_mask), "R9", "irq", irq, |(m_raw & irq_mask));
    end
  end

  task automatic do_load(input logic [SEC_W-1:0] v);
    @(negedge clk); load_value = v; load_strobe = 1'b1;
    @(negedge clk); load_strobe = 1'b0;
  endtask

  task automatic measure_second(input int exp_len, input string req);
    logic [SEC_W-1:0] start;
    int n;
    start = sec_count;
    n = 0;
    while (sec_count == start && n < 100) begin
      @(posedge clk); #5; n++;
    end
    chk(n == exp_len, req, "second length", n, exp_len);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sec_count == '0 && sub_count == '0, "R1", "counts after reset", {sec_count, sub_count}, 0);
    chk(raw_status == 2'b00 && irq == 1'b0, "R1", "status after reset", {raw_status, irq}, 0);
    rst_n = 1'b1;
    idle(2);
    chk(sub_count == '0, "R2", "held while stopped", sub_count, 0);

    // R2/R3: continuous stepping, then sparse stepping
    run_en = 1'b1; osc_tick = 1'b1;
    idle(40);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); osc_tick = (i % 3 == 0);
    end
    // R2: ticks ignored while disabled
    @(negedge clk); run_en = 1'b0; osc_tick = 1'b1;
    begin
      logic [TRIM_W-1:0] s0;
      s0 = sub_count;
      idle(6);
      chk(sub_count == s0, "R2", "frozen with run_en low", sub_count, s0);
    end

    // R5: load while stopped, with osc_tick high
    do_load(32'd50);
    chk(sec_count == 32'd50 && sub_count == '0, "R5", "load while stopped", sec_count, 50);

    // R4: trim at nominal, above, below
    run_en = 1'b1; osc_tick = 1'b1;
    trim_value = TRIM_W'(NOM);
    do_load(32'd100);
    for (int k = 0; k < TE; k++) measure_second(NOM + 1, "R3");
    trim_value = TRIM_W'(11);
    do_load(32'd100);
    for (int k = 0; k < TE - 1; k++) measure_second(NOM + 1, "R3");
    measure_second(12, "R4");
    trim_value = TRIM_W'(3);
    for (int k = 0; k < TE - 1; k++) measure_second(NOM + 1, "R3");
    measure_second(4, "R4");
    // R5: load resets the epoch mid-way
    measure_second(NOM + 1, "R3");
    do_load(32'd7);
    for (int k = 0; k < TE - 1; k++) measure_second(NOM + 1, "R5");
    measure_second(4, "R4");
    trim_value = TRIM_W'(NOM);

    // R6: match on seconds plus sub-count
    irq_mask = 2'b01;
    match0_sec = 32'd200; match0_sub = 3'd5;
    do_load(32'd200);
    chk(raw_status[0] == 1'b0, "R6", "no hit before sub match", raw_status[0], 0);
    idle(6);
    chk(raw_status[0] == 1'b1, "R6", "match0 latched", raw_status[0], 1);
    chk(irq == 1'b1, "R9", "irq with mask", irq, 1);
    // R8: clear
    @(negedge clk); status_clr = 2'b01;
    @(negedge clk); status_clr = 2'b00;
    chk(raw_status[0] == 1'b0, "R8", "match0 cleared", raw_status[0], 0);

    // R7: seconds-only match on roll
    match1_sec = 32'd202;
    irq_mask = 2'b00;
    idle(20);
    chk(raw_status[1] == 1'b1, "R7", "match1 on roll", raw_status[1], 1);
    chk(irq == 1'b0 && masked_status == 2'b00, "R9", "masked off", masked_status, 0);
    // R8: clear concurrent with a hit from a load keeps the bit set
    @(negedge clk); load_value = 32'd202; load_strobe = 1'b1; status_clr = 2'b10;
    @(negedge clk); load_strobe = 1'b0; status_clr = 2'b00;
    chk(raw_status[1] == 1'b1, "R8", "set wins over clear", raw_status[1], 1);
    @(negedge clk); status_clr = 2'b10;
    @(negedge clk); status_clr = 2'b00;
    chk(raw_status[1] == 1'b0, "R8", "match1 cleared", raw_status[1], 0);
    idle(3);
    chk(raw_status[1] == 1'b0, "R7", "no retrigger inside second", raw_status[1], 0);
    irq_mask = 2'b10;

    // R3: wrap of the seconds counter
    match1_sec = 32'd0;
    do_load(32'hFFFF_FFFF);
    idle(10);
    chk(sec_count == 32'd0, "R3", "seconds wrap", sec_count, 0);
    chk(irq == 1'b1, "R9", "irq from match1", irq, 1);

    // Mixed traffic against the model
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      osc_tick = (i % 2 == 0) || (i % 7 == 0);
      run_en = (i % 50) < 45;
      status_clr = (i % 37 == 0) ? 2'b11 : 2'b00;
      trim_value = TRIM_W'(5 + (i / 60));
    end
    @(negedge clk); status_clr = 2'b00;
    idle(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule